// File: doc/BRIEF.md
# Display Serial Command/Data Serializer

This block turns a stream of bytes into the serial waveform a small display panel expects on its write port. Every byte carries a flag that marks it as a command or as a parameter/pixel byte. The flag can travel in two ways. In the three-wire framing it goes out as an extra leading bit, so each frame is nine clocks long. In the four-wire framing it is driven on a dedicated command/data pin, and the frame carries only the byte. The four-wire framing can also pad each byte into a 16-bit word. The upper half of that word is zero and the byte sits in the lower half.

Upstream logic presents bytes with a valid/ready handshake and marks the final byte of a burst. Chip select falls when the first byte of a burst is accepted. It stays low through every word of the burst, including any idle time between words, and rises when the clock falls after the last bit of the word flagged as last. The framing mode, the word size and the serial clock half-period are static configuration inputs. Data changes only while the serial clock is low, so the panel samples on the rising edge.

Top module: `pser_top`

## Requirements
- R1: Out of reset and between bursts, cs_n is 1, sck is 0, busy is 0 and cd is 0. With a valid mode code, in_ready is 1 when idle.
- R2: With cfg_mode = 1 (three-wire), each byte is a frame of 9 sck rising edges. The first bit on dout is the flag (0 = command, 1 = data), followed by data bit 7 down to bit 0. cd stays 0 while cs_n is low.
- R3: With cfg_mode = 2 and cfg_wide = 0, each byte is a frame of 8 rising edges, bit 7 first. At every rising edge of a word, cd equals that byte's flag (0 = command, 1 = data).
- R4: With cfg_mode = 2 and cfg_wide = 1, each byte is a frame of 16 rising edges. The first 8 bits are 0, then data bit 7 down to bit 0 follow. cd holds the byte's flag for all 16 edges.
- R5: cs_n goes low when the first byte of a burst is accepted. It stays low between the words of the burst, even when the next byte arrives late. It rises exactly once per burst, on the same system clock edge where sck falls after the last bit of the byte marked in_last.
- R6: sck idles low. dout and cd change only while sck is low, so both are stable across each high phase.
- R7: Each sck half-period lasts max(cfg_half_div, 2) system clocks. The first rising edge comes that many clocks after cs_n falls.
- R8: in_ready is 0 from the acceptance of a byte until its word has fully shifted out. Inside a burst, in_ready returns to 1 with cs_n still low.
- R9: With a cfg_mode value other than 1 or 2, in_ready stays 0, no byte is accepted and cs_n stays high.
- R10: busy is 1 exactly while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Framing code: 1 three-wire, 2 four-wire, others invalid |
| cfg_wide | input | 1 | Four-wire word size: 0 for 8 bits, 1 for 16-bit padded |
| cfg_half_div | input | DIV_W | sck half-period in system clocks (values below 2 act as 2) |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte value |
| in_is_data | input | 1 | Flag: 0 command, 1 data |
| in_last | input | 1 | Byte ends the burst |
| in_ready | output | 1 | Byte can be accepted this cycle |
| sck | output | 1 | Serial clock |
| dout | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low chip select |
| cd | output | 1 | Command/data pin (four-wire only) |
| busy | output | 1 | A burst is in progress |

## Verification
A wrong bit counter shows up at the ports within a single word: the frame has one clock too few or too many, and every later bit in the burst moves position. A stuck or early chip-select release appears as an extra rise of cs_n before the last byte's final falling clock edge. A wrong half-period count shows up on the very first sck rise after cs_n falls, and again between any two rises inside a word. A command/data flag routed to the wrong place shows up at the first rising edge of the affected word, either on dout in three-wire framing or on cd in four-wire framing.

// File: rtl/pser_pkg.sv
package pser_pkg;

  localparam logic [1:0] MODE_3W = 2'd1;
  localparam logic [1:0] MODE_4W = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_HOLD = 2'd3
  } pser_state_e;

  function automatic logic mode_valid(input logic [1:0] mode);
    return (mode == MODE_3W) || (mode == MODE_4W);
  endfunction

endpackage

// File: rtl/pser_sck_gen.sv
module pser_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             half_done
);

  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] d);
    return (d < MIN_HALF) ? MIN_HALF : d;
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim       = eff_half(half_div) - DIV_W'(1);
  assign half_done = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || half_done) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/pser_word_fmt.sv
module pser_word_fmt #(
  parameter int DATA_W = 8,
  parameter int SH_W   = 2 * DATA_W,
  parameter int CNT_W  = $clog2(SH_W + 1)
) (
  input  logic              three_wire,
  input  logic              wide,
  input  logic              is_data,
  input  logic [DATA_W-1:0] data,
  output logic [SH_W-1:0]   frame,
  output logic [CNT_W-1:0]  nbits
);

  function automatic logic [CNT_W-1:0] frame_len(input logic tw, input logic wd);
    if (tw)      return CNT_W'(DATA_W + 1);
    else if (wd) return CNT_W'(SH_W);
    else         return CNT_W'(DATA_W);
  endfunction

  function automatic logic [SH_W-1:0] frame_pack(input logic tw, input logic wd,
                                                 input logic flag,
                                                 input logic [DATA_W-1:0] d);
    if (tw)      return {flag, d, (DATA_W - 1)'(0)};
    else if (wd) return {DATA_W'(0), d};
    else         return {d, DATA_W'(0)};
  endfunction

  assign frame = frame_pack(three_wire, wide, is_data, data);
  assign nbits = frame_len(three_wire, wide);

endmodule

// File: rtl/pser_shifter.sv
module pser_shifter #(
  parameter int SH_W  = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SH_W-1:0]  frame,
  input  logic [CNT_W-1:0] nbits,
  output logic             msb,
  output logic             final_bit
);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= frame;
      left_q <= nbits;
    end else if (step) begin
      sh_q   <= {sh_q[SH_W-2:0], 1'b0};
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign msb       = sh_q[SH_W-1];
  assign final_bit = (left_q == CNT_W'(1));

endmodule

// File: rtl/pser_top.sv
module pser_top #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_wide,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_is_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              sck,
  output logic              dout,
  output logic              cs_n,
  output logic              cd,
  output logic              busy
);
  import pser_pkg::*;

  localparam int SH_W  = 2 * DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  pser_state_e state_q;
  logic sck_q, cs_n_q, cd_q, last_q;

  logic mode_ok, three_wire, accept, run, half_done;
  logic rise_ev, fall_ev, word_end, burst_end, step, final_bit;
  logic [SH_W-1:0]  frame;
  logic [CNT_W-1:0] nbits;

  assign mode_ok    = mode_valid(cfg_mode);
  assign three_wire = (cfg_mode == MODE_3W);
  assign in_ready   = mode_ok && ((state_q == ST_IDLE) || (state_q == ST_HOLD));
  assign accept     = in_valid && in_ready;
  assign run        = (state_q == ST_LOW) || (state_q == ST_HIGH);

  // Named events for the checker and for readability
  assign rise_ev   = (state_q == ST_LOW)  && half_done;
  assign fall_ev   = (state_q == ST_HIGH) && half_done;
  assign word_end  = fall_ev && final_bit;
  assign burst_end = word_end && last_q;
  assign step      = fall_ev && !final_bit;

  pser_sck_gen #(.DIV_W(DIV_W)) clkgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_div  (cfg_half_div),
    .half_done (half_done)
  );

  pser_word_fmt #(.DATA_W(DATA_W), .SH_W(SH_W), .CNT_W(CNT_W)) fmt_i (
    .three_wire (three_wire),
    .wide       (cfg_wide),
    .is_data    (in_is_data),
    .data       (in_data),
    .frame      (frame),
    .nbits      (nbits)
  );

  pser_shifter #(.SH_W(SH_W), .CNT_W(CNT_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step      (step),
    .frame     (frame),
    .nbits     (nbits),
    .msb       (dout),
    .final_bit (final_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      cd_q    <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            state_q <= ST_LOW;
            cs_n_q  <= 1'b0;
            cd_q    <= three_wire ? 1'b0 : in_is_data;
            last_q  <= in_last;
          end
        end
        ST_LOW: begin
          if (rise_ev) begin
            state_q <= ST_HIGH;
            sck_q   <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (fall_ev) begin
            sck_q <= 1'b0;
            if (burst_end) begin
              state_q <= ST_IDLE;
              cs_n_q  <= 1'b1;
              cd_q    <= 1'b0;
            end else if (word_end) begin
              state_q <= ST_HOLD;
            end else begin
              state_q <= ST_LOW;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck  = sck_q;
  assign cs_n = cs_n_q;
  assign cd   = cd_q;
  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pser_chk.sv
module pser_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic [DIV_W-1:0] cfg_half_div,
  input logic             in_ready,
  input logic             sck,
  input logic             dout,
  input logic             cs_n,
  input logic             cd,
  input logic             busy
);

  logic [DIV_W:0] hi_len;
  logic [DIV_W:0] want_half;

  assign want_half = (cfg_half_div < DIV_W'(2)) ? (DIV_W + 1)'(2) : {1'b0, cfg_half_div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= '0;
    else if (sck) hi_len <= hi_len + (DIV_W + 1)'(1);
    else          hi_len <= '0;
  end

  // R1
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2
  cd_low_3w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && !cs_n) |-> !cd);

  // R3
  cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(cd));

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sck && $past(sck)));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(dout));

  // R7
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_len == want_half));

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sck);

  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mode == 2'd1 || cfg_mode == 2'd2) |-> !in_ready);

  // R10
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

endmodule

bind pser_top pser_chk #(.DIV_W(DIV_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mode     (cfg_mode),
  .cfg_half_div (cfg_half_div),
  .in_ready     (in_ready),
  .sck          (sck),
  .dout         (dout),
  .cs_n         (cs_n),
  .cd           (cd),
  .busy         (busy)
);

// File: tb/pser_top_tb_top.sv
`timescale 1ns/1ps
module pser_top_tb_top;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd2;
  logic cfg_wide = 1'b0;
  logic [DIV_W-1:0] cfg_half_div = 8'd2;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_is_data = 1'b0;
  logic in_last = 1'b0;
  logic in_ready, sck, dout, cs_n, cd, busy;

  always #2 clk = ~clk;

  pser_top #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
    .cfg_half_div(cfg_half_div), .in_valid(in_valid), .in_data(in_data),
    .in_is_data(in_is_data), .in_last(in_last), .in_ready(in_ready),
    .sck(sck), .dout(dout), .cs_n(cs_n), .cd(cd), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // port monitor, sampled on the falling system clock edge
  bit rx_d [0:255];
  bit rx_c [0:255];
  int rx_t [0:255];
  int rx_n = 0;
  int cyc = 0;
  int cs_rises = 0;
  int cs_fall_t = 0;
  bit sck_prev = 1'b0;
  bit cs_prev = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (sck && !sck_prev && rx_n < 256) begin
        rx_d[rx_n] = dout;
        rx_c[rx_n] = cd;
        rx_t[rx_n] = cyc;
        rx_n = rx_n + 1;
      end
      if (cs_n && !cs_prev) cs_rises = cs_rises + 1;
      if (!cs_n && cs_prev) cs_fall_t = cyc;
    end
    sck_prev = sck;
    cs_prev = cs_n;
  end

  // stimulus bytes and expected stream
  logic [7:0] tx_b [0:7];
  bit tx_f [0:7];
  bit ex_d [0:255];
  bit ex_c [0:255];
  int ex_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input bit d, input bit c);
    ex_d[ex_n] = d;
    ex_c[ex_n] = c;
    ex_n = ex_n + 1;
  endtask

  task automatic build_exp(input logic [1:0] mode, input bit wide, input int n);
    ex_n = 0;
    for (int i = 0; i < n; i++) begin
      if (mode == 2'd1) begin
        push_exp(tx_f[i], 1'b0);
        for (int b = 7; b >= 0; b--) push_exp(tx_b[i][b], 1'b0);
      end else begin
        if (wide) for (int z = 0; z < 8; z++) push_exp(1'b0, tx_f[i]);
        for (int b = 7; b >= 0; b--) push_exp(tx_b[i][b], tx_f[i]);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit f, input bit last);
    bit rdy;
    int guard;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_is_data = f; in_last = last;
    guard = 0;
    do begin
      rdy = in_ready;
      @(negedge clk);
      guard = guard + 1;
    end while (!rdy && guard < 5000);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!(cs_n && !busy) && guard < 20000) begin
      @(negedge clk);
      guard = guard + 1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic start_capture();
    @(negedge clk);
    rx_n = 0;
    cs_rises = 0;
  endtask

  task automatic run_burst(input string req, input logic [1:0] mode, input bit wide,
                           input logic [7:0] div, input int n, input int gap);
    int bad_d, bad_c, first;
    cfg_mode = mode; cfg_wide = wide; cfg_half_div = div;
    start_capture();
    for (int i = 0; i < n; i++) begin
      send_byte(tx_b[i], tx_f[i], i == n - 1);
      repeat (gap) @(negedge clk);
    end
    wait_idle();
    build_exp(mode, wide, n);
    chk(rx_n == ex_n, req, "clock edge count", rx_n, ex_n);
    bad_d = 0; bad_c = 0; first = -1;
    for (int k = 0; k < ex_n && k < rx_n; k++) begin
      if (rx_d[k] != ex_d[k]) begin bad_d++; if (first < 0) first = k; end
      if (rx_c[k] != ex_c[k]) bad_c++;
    end
    chk(bad_d == 0, req, "dout bit mismatches (first index in log)", bad_d, 0);
    if (bad_d != 0) $display("  first mismatching bit index %0d", first);
    chk(bad_c == 0, req, "cd level mismatches", bad_c, 0);
    chk(cs_rises == 1, "R5", "cs_n rises per burst", cs_rises, 1);
  endtask

  // R1: reset and idle values
  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n idle", cs_n, 1);
    chk(sck == 1'b0, "R1", "sck idle", sck, 0);
    chk(busy == 1'b0 && cd == 1'b0, "R1", "busy/cd idle", {busy, cd}, 0);
    chk(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
  endtask

  // R2: three-wire framing, command then data bytes
  task automatic t_three_wire();
    tx_b[0] = 8'h2C; tx_f[0] = 1'b0;
    tx_b[1] = 8'hA5; tx_f[1] = 1'b1;
    tx_b[2] = 8'h3C; tx_f[2] = 1'b1;
    run_burst("R2", 2'd1, 1'b0, 8'd2, 3, 0);
  endtask

  // R3, R5: four-wire 8-bit words with late bytes inside the burst
  task automatic t_four_wire8();
    tx_b[0] = 8'h36; tx_f[0] = 1'b0;
    tx_b[1] = 8'h81; tx_f[1] = 1'b1;
    tx_b[2] = 8'h7E; tx_f[2] = 1'b1;
    tx_b[3] = 8'h01; tx_f[3] = 1'b0;
    run_burst("R3", 2'd2, 1'b0, 8'd3, 4, 7);
  endtask

  // R4: padded 16-bit words; wide flag also set in three-wire must not pad
  task automatic t_four_wire16();
    tx_b[0] = 8'hB2; tx_f[0] = 1'b1;
    tx_b[1] = 8'h11; tx_f[1] = 1'b0;
    run_burst("R4", 2'd2, 1'b1, 8'd2, 2, 0);
    tx_b[0] = 8'hF0; tx_f[0] = 1'b1;
    run_burst("R2", 2'd1, 1'b1, 8'd2, 1, 0);
  endtask

  // R7: half-period from the divider, with clamp to 2
  task automatic t_divider(input logic [7:0] div, input int eff);
    tx_b[0] = 8'h5A; tx_f[0] = 1'b1;
    run_burst("R7", 2'd2, 1'b0, div, 1, 0);
    chk(rx_t[0] - cs_fall_t == eff, "R7", "cs fall to first rise", rx_t[0] - cs_fall_t, eff);
    chk(rx_t[7] - rx_t[0] == 14 * eff, "R7", "seven sck periods", rx_t[7] - rx_t[0], 14 * eff);
  endtask

  // R8, R10: ready and busy inside a burst
  task automatic t_hold();
    int guard = 0;
    cfg_mode = 2'd2; cfg_wide = 1'b0; cfg_half_div = 8'd2;
    start_capture();
    send_byte(8'hC3, 1'b1, 1'b0);
    chk(in_ready == 1'b0, "R8", "ready while shifting", in_ready, 0);
    chk(busy == 1'b1 && cs_n == 1'b0, "R10", "busy with cs low", busy, 1);
    while (rx_n < 8 && guard < 1000) begin @(negedge clk); guard++; end
    repeat (10) @(negedge clk);
    chk(in_ready == 1'b1, "R8", "ready between words", in_ready, 1);
    chk(cs_n == 1'b0 && busy == 1'b1, "R10", "cs held low between words", cs_n, 0);
    send_byte(8'h3C, 1'b0, 1'b1);
    wait_idle();
    chk(rx_n == 16, "R8", "edges for two words", rx_n, 16);
    chk(cs_rises == 1 && busy == 1'b0, "R10", "one release then idle", cs_rises, 1);
  endtask

  // R9: invalid mode codes accept nothing
  task automatic t_bad_mode(input logic [1:0] mode);
    int ready_seen = 0;
    int cs_low_seen = 0;
    cfg_mode = mode;
    start_capture();
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hFF; in_is_data = 1'b1; in_last = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (in_ready) ready_seen++;
      if (!cs_n) cs_low_seen++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(ready_seen == 0, "R9", "ready cycles with invalid mode", ready_seen, 0);
    chk(cs_low_seen == 0 && rx_n == 0, "R9", "activity with invalid mode", cs_low_seen + rx_n, 0);
    cfg_mode = 2'd2;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_three_wire();
    t_four_wire8();
    t_four_wire16();
    t_divider(8'd5, 5);
    t_divider(8'd0, 2);
    t_divider(8'd3, 3);
    t_hold();
    t_bad_mode(2'd0);
    t_bad_mode(2'd3);
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog run did not complete act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule